// File: doc/BRIEF.md
# Stream Channel Descriptor Controller

This block keeps the head pointers of a banked on-chip stream store. The store holds a set of channels; each channel is a run of 32-bit elements striped across as many banks as there are processing elements. For every channel the controller holds a descriptor with two parts: the address of the next element to take or give, and the address where the channel ends. Software loads the descriptors through a plain configuration port before streaming begins.

At run time a single channel is picked per access, together with the number of elements that the processing elements will consume or produce on that access, from zero up to the bank count. The controller answers with the head address, already split into bank and row, for one wide access across all banks. It also returns the number of elements actually granted and an error flag. It then moves the head forward by the granted amount. Asking for more than is left grants only what remains. Asking anything of a channel that is already exhausted grants nothing. Both cases raise the error flag.

The request side is valid/ready, and so is the response side. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Its answer sits in a single output register. That register is loaded on the next edge and is held unchanged until the edge where `rsp_ready` is high. While an answer waits, `req_ready` stays low, so back-pressure from the response side passes straight to the request side. The configuration port needs no handshake. While it writes, `req_ready` is low.

Top module: `scd_ctrl`

## Requirements
- R1: After reset no response is pending, `req_ready` is high, and every descriptor has head and end both at 0, so each channel reads as exhausted.
- R2: A configuration write sets the head and end of the addressed channel. The next access to that channel returns the written head as its base.
- R3: A request accepted on edge k yields `rsp_valid` high after edge k. The response carries the channel's head before the access as `rsp_base`. When the count fits in the remaining elements, it also carries `rsp_count` equal to the request count and `rsp_err` = 0.
- R4: Each access moves the head by the granted count. A following access to the same channel, including one accepted on the very next edge, sees the moved head.
- R5: A count of 0 on a non-exhausted channel grants 0, leaves the head where it is and raises no error.
- R6: When the count exceeds end minus head, the response grants end minus head and raises `rsp_err`, and the head is set to the end.
- R7: When head is not below end, the channel is exhausted. The access grants 0, raises `rsp_err` and leaves the head unchanged.
- R8: `rsp_bank` is the base modulo the bank count, and `rsp_row` is the base divided by the bank count. The bank count is a power of two.
- R9: While `rsp_valid` is high and `rsp_ready` is low, all response outputs hold steady and `req_ready` is low.
- R10: `req_ready` is low in any cycle where `cfg_we` is high.
- R11: An access or configuration write to one channel leaves every other channel's descriptor unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_ch | input | CH_W | Channel written |
| cfg_cur | input | ADDR_W | Head address loaded |
| cfg_final | input | ADDR_W | End address loaded |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Access request can be taken |
| req_ch | input | CH_W | Channel accessed |
| req_count | input | CNT_W | Elements wanted, 0 to NUM_BANKS |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_base | output | ADDR_W | Head address before the access |
| rsp_bank | output | BANK_W | Bank of the base element |
| rsp_row | output | ADDR_W-BANK_W | Row of the base element |
| rsp_count | output | CNT_W | Elements granted |
| rsp_err | output | 1 | Overrun or exhausted channel |

## Verification
A request taken on edge k has its response on the outputs right after edge k. The new head takes effect for a request taken on edge k+1. A configuration written on edge k is seen by requests from edge k+1 onward. The driver pushes the expected response at the moment it sees `req_ready` high, half a cycle before the accepting edge. The monitor compares the oldest queued entry at each falling edge where `rsp_valid` and `rsp_ready` are both high, so every result is checked in the cycle it is first due and in order. The stall case is checked at three falling edges while the response is held.

// File: rtl/scd_pkg.sv
package scd_pkg;
  // Outcome of one access against a descriptor
  typedef enum logic [1:0] {
    SCD_OK      = 2'd0,
    SCD_CLIPPED = 2'd1,
    SCD_EMPTY   = 2'd2
  } scd_res_e;
endpackage

// File: rtl/scd_desc_table.sv
module scd_desc_table #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 12,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CH_W-1:0]   cfg_ch,
  input  logic [ADDR_W-1:0] cfg_cur,
  input  logic [ADDR_W-1:0] cfg_final,
  input  logic              upd_en,
  input  logic [CH_W-1:0]   upd_ch,
  input  logic [ADDR_W-1:0] upd_cur,
  input  logic [CH_W-1:0]   rd_ch,
  output logic [ADDR_W-1:0] rd_cur,
  output logic [ADDR_W-1:0] rd_final
);
  logic [ADDR_W-1:0] head_q [NUM_CH];
  logic [ADDR_W-1:0] end_q  [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        head_q[g] <= '0;
        end_q[g]  <= '0;
      end else if (cfg_we && cfg_ch == CH_W'(g)) begin
        head_q[g] <= cfg_cur;
        end_q[g]  <= cfg_final;
      end else if (upd_en && upd_ch == CH_W'(g)) begin
        head_q[g] <= upd_cur;
      end
    end
  end

  assign rd_cur   = head_q[rd_ch];
  assign rd_final = end_q[rd_ch];

  // Request gating at the top must keep the two write ports apart (R10)
  assert_no_port_clash_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && upd_en));
endmodule

// File: rtl/scd_advance.sv
module scd_advance #(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 3
) (
  input  logic [ADDR_W-1:0]    cur,
  input  logic [ADDR_W-1:0]    fin,
  input  logic [CNT_W-1:0]     count,
  output logic [ADDR_W-1:0]    new_cur,
  output logic [CNT_W-1:0]     granted,
  output scd_pkg::scd_res_e    res
);
  import scd_pkg::*;
  logic [ADDR_W-1:0] remain;
  logic [ADDR_W-1:0] count_ext;

  assign remain    = fin - cur;
  assign count_ext = {{(ADDR_W-CNT_W){1'b0}}, count};

  always_comb begin
    if (cur >= fin) begin
      res     = SCD_EMPTY;
      granted = '0;
      new_cur = cur;
    end else if (count_ext > remain) begin
      res     = SCD_CLIPPED;
      granted = remain[CNT_W-1:0];
      new_cur = fin;
    end else begin
      res     = SCD_OK;
      granted = count;
      new_cur = cur + count_ext;
    end
  end

  // Head never passes the end unless it was already there (R6, R7)
  always_comb begin
    assert_head_bound_R6: assert (new_cur <= fin || new_cur == cur);
  end
endmodule

// File: rtl/scd_rsp_reg.sv
module scd_rsp_reg #(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 3,
  parameter int NUM_BANKS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] in_base,
  input  logic [CNT_W-1:0]  in_count,
  input  logic              in_err,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_base,
  output logic [CNT_W-1:0]  out_count,
  output logic              out_err
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_base  <= '0;
      out_count <= '0;
      out_err   <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_base  <= in_base;
      out_count <= in_count;
      out_err   <= in_err;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_hold_on_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_base) &&
                                   $stable(out_count) && $stable(out_err)));
  assert_grant_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_count) <= NUM_BANKS));
endmodule

// File: rtl/scd_ctrl.sv
module scd_ctrl #(
  parameter int NUM_CH    = 4,
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 12,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int CNT_W  = $clog2(NUM_BANKS + 1),
  localparam int ROW_W  = ADDR_W - BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CH_W-1:0]   cfg_ch,
  input  logic [ADDR_W-1:0] cfg_cur,
  input  logic [ADDR_W-1:0] cfg_final,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CH_W-1:0]   req_ch,
  input  logic [CNT_W-1:0]  req_count,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_base,
  output logic [BANK_W-1:0] rsp_bank,
  output logic [ROW_W-1:0]  rsp_row,
  output logic [CNT_W-1:0]  rsp_count,
  output logic              rsp_err
);
  import scd_pkg::*;

  logic              fire;
  logic [ADDR_W-1:0] cur, fin, new_cur;
  logic [CNT_W-1:0]  granted;
  scd_res_e          res;

  assign req_ready = (!rsp_valid || rsp_ready) && !cfg_we;
  assign fire      = req_valid && req_ready;

  scd_desc_table #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_cur(cfg_cur), .cfg_final(cfg_final),
    .upd_en(fire), .upd_ch(req_ch), .upd_cur(new_cur),
    .rd_ch(req_ch), .rd_cur(cur), .rd_final(fin)
  );

  scd_advance #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_adv (
    .cur(cur), .fin(fin), .count(req_count),
    .new_cur(new_cur), .granted(granted), .res(res)
  );

  scd_rsp_reg #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .NUM_BANKS(NUM_BANKS)) u_rsp (
    .clk(clk), .rst_n(rst_n), .load(fire),
    .in_base(cur), .in_count(granted), .in_err(res != SCD_OK),
    .out_valid(rsp_valid), .out_ready(rsp_ready),
    .out_base(rsp_base), .out_count(rsp_count), .out_err(rsp_err)
  );

  // Power-of-two striping: bank is the low bits, row the rest
  assign rsp_bank = rsp_base[BANK_W-1:0];
  assign rsp_row  = rsp_base[ADDR_W-1:BANK_W];

  assert_rsp_follows_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(req_valid && req_ready));
endmodule

// File: tb/tb_scd_ctrl.sv
module tb_scd_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int NB  = 4;
  localparam int AW  = 12;
  localparam int CHW = 2;
  localparam int BW  = 2;
  localparam int CW  = 3;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [CHW-1:0] cfg_ch = '0;
  logic [AW-1:0] cfg_cur = '0, cfg_final = '0;
  logic req_valid = 0, req_ready;
  logic [CHW-1:0] req_ch = '0;
  logic [CW-1:0] req_count = '0;
  logic rsp_valid, rsp_ready = 1;
  logic [AW-1:0] rsp_base;
  logic [BW-1:0] rsp_bank;
  logic [AW-BW-1:0] rsp_row;
  logic [CW-1:0] rsp_count;
  logic rsp_err;

  int checks = 0, errors = 0;
  logic [AW-1:0] m_cur [NCH];
  logic [AW-1:0] m_fin [NCH];
  logic [AW+CW:0] exp_q [$];
  string tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  scd_ctrl #(.NUM_CH(NCH), .NUM_BANKS(NB), .ADDR_W(AW)) dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic configure(input int ch, input int cur, input int fin);
    @(negedge clk);
    cfg_we = 1; cfg_ch = CHW'(ch); cfg_cur = AW'(cur); cfg_final = AW'(fin);
    #1 chk(req_ready == 0, "R10 ready low while configuring", int'(req_ready), 0);
    m_cur[ch] = AW'(cur); m_fin[ch] = AW'(fin);
    @(negedge clk);
    cfg_we = 0;
  endtask

  // Driver: computes the expected answer from the model and queues it
  task automatic issue(input int ch, input int cnt, input string tag);
    logic [AW-1:0] base, remain;
    logic [CW-1:0] g;
    logic e;
    @(negedge clk);
    req_valid = 1; req_ch = CHW'(ch); req_count = CW'(cnt);
    while (!req_ready) @(negedge clk);
    base = m_cur[ch];
    remain = m_fin[ch] - m_cur[ch];
    if (m_cur[ch] >= m_fin[ch]) begin g = '0; e = 1; end
    else if (AW'(cnt) > remain) begin g = remain[CW-1:0]; e = 1; m_cur[ch] = m_fin[ch]; end
    else begin g = CW'(cnt); e = 0; m_cur[ch] = m_cur[ch] + AW'(cnt); end
    exp_q.push_back({base, g, e});
    tag_q.push_back(tag);
    @(posedge clk);
    #1 req_valid = 0;
  endtask

  // Monitor: compares each delivered response against the oldest expectation
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        chk(0, "R3 unexpected response", int'(rsp_base), -1);
      end else begin
        logic [AW+CW:0] x;
        string t;
        x = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rsp_base == x[AW+CW:CW+1], {t, " base"}, int'(rsp_base), int'(x[AW+CW:CW+1]));
        chk(rsp_count == x[CW:1], {t, " granted"}, int'(rsp_count), int'(x[CW:1]));
        chk(rsp_err == x[0], {t, " error"}, int'(rsp_err), int'(x[0]));
        chk(int'(rsp_bank) == int'(x[AW+CW:CW+1]) % NB, "R8 bank", int'(rsp_bank),
            int'(x[AW+CW:CW+1]) % NB);
        chk(int'(rsp_row) == int'(x[AW+CW:CW+1]) / NB, "R8 row", int'(rsp_row),
            int'(x[AW+CW:CW+1]) / NB);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [AW-1:0] hb;
    for (int i = 0; i < NCH; i++) begin m_cur[i] = '0; m_fin[i] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(rsp_valid == 0, "R1 no response after reset", int'(rsp_valid), 0);
    chk(req_ready == 1, "R1 ready after reset", int'(req_ready), 1);
    issue(2, 1, "R1 R7 cleared channel exhausted");

    configure(0, 10, 20);
    configure(1, 100, 103);
    configure(3, 7, 7);
    issue(0, 4, "R2 R3 first access");
    issue(0, 3, "R4 back-to-back advance");
    issue(0, 0, "R5 zero count");
    issue(0, 4, "R6 overrun clipped");
    issue(0, 1, "R7 exhausted after clip");
    issue(1, 2, "R3 second channel");
    issue(1, 2, "R6 overrun by one");
    issue(3, 1, "R7 head equals end");
    issue(2, 4, "R11 untouched channel still empty");
    configure(2, 41, 60);
    issue(2, 4, "R8 R11 unaligned base");
    issue(0, 2, "R11 ch0 still exhausted");
    issue(2, 4, "R4 interleaved advance");

    // Back-pressure
    @(posedge clk); #1 rsp_ready = 0;
    issue(2, 3, "R9 stalled response");
    @(negedge clk);
    hb = rsp_base;
    for (int k = 0; k < 3; k++) begin
      chk(rsp_valid == 1, "R9 valid held", int'(rsp_valid), 1);
      chk(rsp_base == hb, "R9 base held", int'(rsp_base), int'(hb));
      chk(req_ready == 0, "R9 ready low under stall", int'(req_ready), 0);
      @(negedge clk);
    end
    @(posedge clk); #1 rsp_ready = 1;
    issue(2, 4, "R4 after stall");
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all responses delivered", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule